// File: doc/BRIEF.md
# Iterative Signed Integer Divider

This block divides an integer dividend by an integer divisor over several clock cycles and returns a quotient and a remainder. A one-cycle `start` strobe, given while the block is idle, captures both operands, a per-operand signed flag and a rounding selection. A one-cycle `done` strobe later marks the cycle in which the results are new. The results then stay on the outputs until the next `done`.

Rounding has two settings:

- **Truncating mode** rounds the quotient toward zero. The remainder then carries the sign of the dividend.
- **Flooring mode** rounds the quotient toward negative infinity. The remainder then carries the sign of the divisor.

Inside the block, an unsigned restoring divider works on operand magnitudes and produces one quotient bit per clock. A correction stage then puts the signs back. In flooring mode, when the operands have opposite signs and the remainder is not zero, it also steps the quotient down by one and adds the divisor to the remainder.

The remainder output is one bit wider than the wider operand, so every remainder is exact in two's complement. The quotient has the dividend's width and keeps only its low bits.

Top module: `int_divider`

## Requirements
- R1: In truncating mode (`floor_mode`=0) the quotient is the exact quotient rounded toward zero, kept to NUM_W bits. The remainder equals dividend minus quotient times divisor, in REM_W-bit two's complement. A nonzero remainder has the sign of the dividend.
- R2: In flooring mode (`floor_mode`=1) the quotient is rounded toward negative infinity. A nonzero remainder has the sign of the divisor, and its magnitude is below that of the divisor.
- R3: Worked values:
  - 10 / 3 gives 3 rem 1 in both modes.
  - -10 / -3 gives 3 rem -1 in both modes.
  - -10 / 3 gives -3 rem -1 when truncating and -4 rem 2 when flooring.
  - 10 / -3 gives -3 rem 1 when truncating and -4 rem -2 when flooring.
- R4: `num_signed` and `den_signed` select, per operand, a two's-complement or an unsigned reading. With both flags clear the result is the unsigned one, and both modes give the same outputs. Mixed settings are allowed.
- R5: `done` is high for exactly one cycle, on the (NUM_W+1)-th rising edge after the edge that accepted `start`. `quo`, `rem` and `div_zero` change only on the edge that raises `done`.
- R6: A zero divisor gives an all-ones quotient and a remainder equal to the dividend, extended according to `num_signed`. `div_zero` is high together with that `done`. `div_zero` is low at every other time.
- R7: A `start` pulse arriving while `busy` is high is ignored: it produces no extra `done` and does not alter the running division.
- R8: During reset, `busy`, `done`, `div_zero`, `quo` and `rem` are all zero.
- R9: A quotient outside the NUM_W-bit range wraps to its low NUM_W bits; for example, signed -128 / -1 with NUM_W=8 gives 8'h80 rem 0.
- R10: `busy` is high from the accepting edge until the edge that raises `done`, and it is low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division; accepted only when `busy` is low |
| num | input | NUM_W | Dividend |
| den | input | DEN_W | Divisor |
| num_signed | input | 1 | Dividend is two's complement when high |
| den_signed | input | 1 | Divisor is two's complement when high |
| floor_mode | input | 1 | 0 selects truncating rounding, 1 selects flooring rounding |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle strobe marking new results |
| quo | output | NUM_W | Quotient, low NUM_W bits |
| rem | output | REM_W | Remainder, two's complement, REM_W = max(NUM_W,DEN_W)+1 |
| div_zero | output | 1 | The completed division had a zero divisor |

## Verification
Every result of this block is due on one known edge: the (NUM_W+1)-th rising edge after the edge that took `start`. The results and `done` are all registered together on that edge. When the driver presents an operand pair, it computes the expected quotient, remainder and zero flag from the rounding rules. It stamps that entry with the cycle number at which `done` must appear, and pushes it into the scoreboard queue. The monitor samples on falling edges. Whenever it sees `done`, it pops the oldest entry, compares the three results, and compares the current cycle number with the stamp. Any `done` with nothing queued is reported as an ignored-start violation.

// File: rtl/idiv_pkg.sv
// Shared definitions for the iterative divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package idiv_pkg;

    // Rounding selection carried through the divider
    typedef enum logic {
        DIV_TRUNC = 1'b0,
        DIV_FLOOR = 1'b1
    } div_mode_e;

endpackage

// File: rtl/idiv_prep.sv
// Operand preparation: turns a raw operand into a sign bit and an unsigned magnitude.
// Assumes W >= 2; the most negative value maps to magnitude 2**(W-1), which fits in W bits.
module idiv_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         is_signed,
    output logic [W-1:0] mag,
    output logic         neg
);

    // Sign detection and two's-complement negation of negative operands
    always_comb begin
        neg = is_signed & val[W-1];
        mag = neg ? (~val + 1'b1) : val;
    end

endmodule

// File: rtl/idiv_restore.sv
// Unsigned restoring divider, one quotient bit per clock.
// Assumes NUM_W >= 2. A load is taken only while idle.
// fin pulses for one cycle once q_mag and r_mag hold the final values;
// those values remain until the next load.
module idiv_restore #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num_mag,
    input  logic [DEN_W-1:0] den_mag,
    output logic             busy,
    output logic             fin,
    output logic [NUM_W-1:0] q_mag,
    output logic [DEN_W-1:0] r_mag
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] part_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] shf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             fin_q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W+1:0] trial;
    logic             take;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {part_q, shf_q[NUM_W-1]};
        trial   = {1'b0, shifted} - {2'b00, den_q};
        take    = ~trial[DEN_W+1];
    end

    // Iteration state: partial remainder, dividend/quotient shifter, bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            den_q  <= '0;
            shf_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load && !busy_q) begin
                part_q <= '0;
                shf_q  <= num_mag;
                den_q  <= den_mag;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                part_q <= take ? trial[DEN_W-1:0] : shifted[DEN_W-1:0];
                shf_q  <= {shf_q[NUM_W-2:0], take};
                cnt_q  <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign fin   = fin_q;
    assign q_mag = shf_q;
    assign r_mag = part_q;

endmodule

// File: rtl/idiv_fixup.sv
// Sign restoration and rounding correction for a magnitude quotient and remainder.
// Assumes r_mag < den_mag whenever den_mag is nonzero, and REM_W > max(NUM_W, DEN_W).
// Flooring moves the quotient down by one and adds the signed divisor
// to the remainder when the signs differ and the remainder is nonzero.
module idiv_fixup #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 8,
    parameter int REM_W = 9
) (
    input  logic             [NUM_W-1:0] q_mag,
    input  logic             [DEN_W-1:0] r_mag,
    input  logic             [DEN_W-1:0] den_mag,
    input  logic                         n_neg,
    input  logic                         d_neg,
    input  idiv_pkg::div_mode_e          mode,
    output logic             [NUM_W-1:0] quo,
    output logic             [REM_W-1:0] rem
);

    logic [NUM_W:0]   q_ext;
    logic [NUM_W:0]   q_t;
    logic [NUM_W:0]   q_f;
    logic [REM_W-1:0] r_ext;
    logic [REM_W-1:0] r_t;
    logic [REM_W-1:0] r_f;
    logic [REM_W-1:0] d_ext;
    logic [REM_W-1:0] d_s;
    logic             adjust;

    // Truncated signed results, then the optional flooring step
    always_comb begin
        q_ext  = {1'b0, q_mag};
        q_t    = (n_neg ^ d_neg) ? (~q_ext + 1'b1) : q_ext;
        r_ext  = REM_W'(r_mag);
        r_t    = n_neg ? (~r_ext + 1'b1) : r_ext;
        d_ext  = REM_W'(den_mag);
        d_s    = d_neg ? (~d_ext + 1'b1) : d_ext;
        adjust = (mode == idiv_pkg::DIV_FLOOR) && (r_mag != '0) && (n_neg != d_neg);
        q_f    = adjust ? (q_t - 1'b1) : q_t;
        r_f    = adjust ? (r_t + d_s) : r_t;
        quo    = q_f[NUM_W-1:0];
        rem    = r_f;
    end

endmodule

// File: rtl/int_divider.sv
// Iterative signed/unsigned integer divider with truncating or flooring rounding.
// Accepts start only while idle. Results and done are registered NUM_W+1 edges
// after the accepting edge and hold until the next done.
// A zero divisor gives an all-ones quotient, the extended dividend as remainder,
// and div_zero. Assumes NUM_W >= 2 and DEN_W >= 2.
module int_divider #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 8,
    localparam int REM_W = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    input  logic             num_signed,
    input  logic             den_signed,
    input  logic             floor_mode,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quo,
    output logic [REM_W-1:0] rem,
    output logic             div_zero
);

    import idiv_pkg::*;

    logic [NUM_W-1:0] num_mag;
    logic [DEN_W-1:0] den_mag;
    logic             num_neg;
    logic             den_neg;
    logic             accept;
    logic             core_busy;
    logic             core_fin;
    logic [NUM_W-1:0] core_q;
    logic [DEN_W-1:0] core_r;
    logic [NUM_W-1:0] fx_quo;
    logic [REM_W-1:0] fx_rem;

    div_mode_e        mode_q;
    logic             n_neg_q;
    logic             d_neg_q;
    logic             dz_q;
    logic [DEN_W-1:0] den_mag_q;
    logic [REM_W-1:0] num_x_q;

    logic             done_q;
    logic             dz_out_q;
    logic [NUM_W-1:0] quo_q;
    logic [REM_W-1:0] rem_q;

    idiv_prep #(.W(NUM_W)) u_prep_num (
        .val       (num),
        .is_signed (num_signed),
        .mag       (num_mag),
        .neg       (num_neg)
    );

    idiv_prep #(.W(DEN_W)) u_prep_den (
        .val       (den),
        .is_signed (den_signed),
        .mag       (den_mag),
        .neg       (den_neg)
    );

    assign accept = start & ~busy;

    // Per-division context captured at the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= DIV_TRUNC;
            n_neg_q   <= 1'b0;
            d_neg_q   <= 1'b0;
            dz_q      <= 1'b0;
            den_mag_q <= '0;
            num_x_q   <= '0;
        end else if (accept) begin
            mode_q    <= div_mode_e'(floor_mode);
            n_neg_q   <= num_neg;
            d_neg_q   <= den_neg;
            dz_q      <= (den == '0);
            den_mag_q <= den_mag;
            num_x_q   <= {{(REM_W-NUM_W){num_signed & num[NUM_W-1]}}, num};
        end
    end

    idiv_restore #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .busy    (core_busy),
        .fin     (core_fin),
        .q_mag   (core_q),
        .r_mag   (core_r)
    );

    idiv_fixup #(.NUM_W(NUM_W), .DEN_W(DEN_W), .REM_W(REM_W)) u_fix (
        .q_mag   (core_q),
        .r_mag   (core_r),
        .den_mag (den_mag_q),
        .n_neg   (n_neg_q),
        .d_neg   (d_neg_q),
        .mode    (mode_q),
        .quo     (fx_quo),
        .rem     (fx_rem)
    );

    // Result registers loaded once per division, with the zero-divisor override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            dz_out_q <= 1'b0;
            quo_q    <= '0;
            rem_q    <= '0;
        end else begin
            done_q   <= core_fin;
            dz_out_q <= core_fin & dz_q;
            if (core_fin) begin
                quo_q <= dz_q ? '1 : fx_quo;
                rem_q <= dz_q ? num_x_q : fx_rem;
            end
        end
    end

    assign busy     = core_busy | core_fin;
    assign done     = done_q;
    assign div_zero = dz_out_q;
    assign quo      = quo_q;
    assign rem      = rem_q;

endmodule

// File: rtl/int_divider_chk.sv
// Property checker for int_divider, bound to every instance.
// Keeps its own cycle counter and its own copy of each division's context.
module int_divider_chk #(
    parameter int NUM_W = 8,
    parameter int DEN_W = 8,
    localparam int REM_W = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             num_msb,
    input logic             den_msb,
    input logic             num_signed,
    input logic             den_signed,
    input logic             floor_mode,
    input logic             busy,
    input logic             done,
    input logic [NUM_W-1:0] quo,
    input logic [REM_W-1:0] rem,
    input logic             div_zero
);

    localparam int LAT = NUM_W + 1;
    localparam int CW  = $clog2(LAT + 1) + 1;

    logic [CW-1:0] age;
    logic          run;
    logic          c_floor;
    logic          c_nneg;
    logic          c_dneg;
    logic          c_uns;

    // Cycles since the accepting edge, plus the context of that division
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age     <= '0;
            run     <= 1'b0;
            c_floor <= 1'b0;
            c_nneg  <= 1'b0;
            c_dneg  <= 1'b0;
            c_uns   <= 1'b0;
        end else if (start && !busy) begin
            age     <= '0;
            run     <= 1'b1;
            c_floor <= floor_mode;
            c_nneg  <= num_signed & num_msb;
            c_dneg  <= den_signed & den_msb;
            c_uns   <= ~num_signed & ~den_signed;
        end else if (run) begin
            age <= age + 1'b1;
            if (done) run <= 1'b0;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run && age == CW'(LAT))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem))); // R5
    AST_BUSY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done) |-> busy); // R10
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_ZERO_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (quo == '1)); // R6
    AST_ZERO_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done); // R6
    AST_TRUNC_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && !c_floor && rem != '0) |-> (rem[REM_W-1] == c_nneg)); // R1
    AST_FLOOR_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && c_floor && rem != '0) |-> (rem[REM_W-1] == c_dneg)); // R2
    AST_UNSIGNED_REM_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_uns) |-> !rem[REM_W-1]); // R4

endmodule

bind int_divider int_divider_chk #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .num_msb    (num[NUM_W-1]),
    .den_msb    (den[DEN_W-1]),
    .num_signed (num_signed),
    .den_signed (den_signed),
    .floor_mode (floor_mode),
    .busy       (busy),
    .done       (done),
    .quo        (quo),
    .rem        (rem),
    .div_zero   (div_zero)
);

// File: tb/int_divider_test.sv
// Scoreboard bench for int_divider: the driver queues expected results stamped
// with their due cycle; the monitor pops and compares on every done.
module int_divider_test;

    localparam int NW  = 8;
    localparam int DW  = 8;
    localparam int RW  = 9;
    localparam int LAT = NW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] num = '0;
    logic [DW-1:0] den = '0;
    logic          ns = 1'b0;
    logic          ds = 1'b0;
    logic          fm = 1'b0;
    logic          busy;
    logic          done;
    logic [NW-1:0] quo;
    logic [RW-1:0] rem;
    logic          dz;

    int     checks = 0;
    int     fails = 0;
    longint cyc = 0;
    bit     finished = 1'b0;
    bit     done_prev = 1'b0;

    typedef struct {
        logic [NW-1:0] q;
        logic [RW-1:0] r;
        logic          e;
        longint        due;
        string         tag;
    } exp_t;

    exp_t sb[$];

    int_divider #(.NUM_W(NW), .DEN_W(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .num        (num),
        .den        (den),
        .num_signed (ns),
        .den_signed (ds),
        .floor_mode (fm),
        .busy       (busy),
        .done       (done),
        .quo        (quo),
        .rem        (rem),
        .div_zero   (dz)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: compute the expected result, queue it, pulse start, wait out the run
    task automatic issue(longint nval, longint dval, bit nsg, bit dsg, bit flo, string tag);
        exp_t          it;
        logic [NW-1:0] nb;
        logic [DW-1:0] db;
        longint        nv;
        longint        dv;
        longint        q;
        longint        r;
        nb = nval[NW-1:0];
        db = dval[DW-1:0];
        nv = nsg ? longint'(signed'(nb)) : longint'(nb);
        dv = dsg ? longint'(signed'(db)) : longint'(db);
        if (dv == 0) begin
            q = -1;
            r = nv;
            it.e = 1'b1;
        end else begin
            q = nv / dv;
            r = nv % dv;
            if (flo && r != 0 && ((r < 0) != (dv < 0))) begin
                q = q - 1;
                r = r + dv;
            end
            it.e = 1'b0;
        end
        it.q = q[NW-1:0];
        it.r = r[RW-1:0];
        it.tag = tag;
        @(negedge clk);
        num = nb;
        den = db;
        ns = nsg;
        ds = dsg;
        fm = flo;
        start = 1'b1;
        it.due = cyc + 1 + LAT;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    // Monitor: compare each done against the oldest queued expectation
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && done) begin
            if (done_prev) check(1'b0, "R5 done longer than one cycle", 1, 0);
            check(!busy, "R10 busy low at done", busy, 0);
            if (sb.size() == 0) begin
                check(1'b0, "R7 done without accepted start", 1, 0);
            end else begin
                it = sb.pop_front();
                check(quo == it.q, {it.tag, " quotient"}, quo, it.q);
                check(rem == it.r, {it.tag, " remainder"}, rem, it.r);
                check(dz == it.e, {it.tag, " R6 div_zero"}, dz, it.e);
                check(cyc == it.due, {it.tag, " R5 latency"}, cyc, it.due);
            end
        end else if (rst_n && !done) begin
            check(!dz, "R6 div_zero without done", dz, 0);
        end
        done_prev = done;
    end

    initial begin
        longint nlist[9] = '{-100, -7, -1, 0, 1, 7, 100, 127, -128};
        longint dlist[7] = '{-9, -1, 1, 2, 9, 127, -128};

        // R8: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 busy in reset", busy, 0);
        check(done == 1'b0, "R8 done in reset", done, 0);
        check(dz == 1'b0, "R8 div_zero in reset", dz, 0);
        check(quo == '0, "R8 quo in reset", quo, 0);
        check(rem == '0, "R8 rem in reset", rem, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: worked values in both modes
        issue(10, 3, 1, 1, 0, "R3 10/3 trunc");
        issue(10, 3, 1, 1, 1, "R3 10/3 floor");
        issue(-10, -3, 1, 1, 0, "R3 -10/-3 trunc");
        issue(-10, -3, 1, 1, 1, "R3 -10/-3 floor");
        issue(-10, 3, 1, 1, 0, "R3 -10/3 trunc");
        issue(-10, 3, 1, 1, 1, "R3 -10/3 floor");
        issue(10, -3, 1, 1, 0, "R3 10/-3 trunc");
        issue(10, -3, 1, 1, 1, "R3 10/-3 floor");

        // R1, R2: sign-combination sweep of signed operands
        foreach (nlist[i]) begin
            foreach (dlist[j]) begin
                issue(nlist[i], dlist[j], 1, 1, 0, "R1 signed sweep");
                issue(nlist[i], dlist[j], 1, 1, 1, "R2 signed sweep");
            end
        end

        // R4: unsigned and mixed readings
        issue(200, 7, 0, 0, 0, "R4 unsigned trunc");
        issue(200, 7, 0, 0, 1, "R4 unsigned floor");
        issue(255, 254, 0, 0, 1, "R4 unsigned large floor");
        issue(200, -7, 0, 1, 0, "R4 mixed trunc");
        issue(200, -7, 0, 1, 1, "R4 mixed floor");
        issue(-128, 255, 1, 0, 1, "R4 mixed unsigned divisor floor");

        // R9: quotient wrap
        issue(-128, -1, 1, 1, 0, "R9 wrap trunc");
        issue(-128, -1, 1, 1, 1, "R9 wrap floor");

        // R6: zero divisor
        issue(-5, 0, 1, 1, 1, "R6 signed zero divisor");
        issue(200, 0, 0, 0, 0, "R6 unsigned zero divisor");

        // R7 and R10: start while busy is ignored, busy stays high mid-run
        issue(0, 0, 0, 0, 0, "R6 zero by zero");
        @(negedge clk);
        num = 8'd100;
        den = 8'd7;
        ns = 1'b1;
        ds = 1'b1;
        fm = 1'b0;
        start = 1'b1;
        begin
            exp_t it;
            it.q = 8'd14;
            it.r = 9'd2;
            it.e = 1'b0;
            it.due = cyc + 1 + LAT;
            it.tag = "R7 run with ignored start";
            sb.push_back(it);
        end
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R10 busy mid-run", busy, 1);
        num = 8'd50;
        den = 8'd3;
        fm = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3 * LAT) @(negedge clk);
        check(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);
        check(busy == 1'b0, "R7 idle after ignored start", busy, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #600000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired R5 actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule